// File: doc/BRIEF.md
# Impedance Frequency Sweep Sequencer

This block is the device-side controller of a stepped-frequency impedance sweep. A host reaches it through a single-byte read/write bus. Over that bus the host programs a 24-bit start frequency word, a 24-bit step word, the number of steps, and a settling count with a multiplier. It then issues mode commands by writing the top nibble of the control-high byte. The block drives the current frequency word and an excitation enable toward a waveform generator. It counts excitation periods for settling. It requests a measurement from an external engine through a request/acknowledge handshake and latches the real and imaginary results together with status flags.

The host moves the sweep forward one point at a time. An initialize command applies the start frequency with no measurement. Start begins settling and then measuring. Increment steps the word and measures again. Repeat measures again at the same word. A separate path requests a 14-bit temperature conversion and holds the result. Power-down and a soft reset in control-low return the sequencer to its idle state and clear every status flag.

Top module: `imp_sweep_seq`

## Requirements
- R1: After reset, status (address 0x8F) reads 0x00, `freq_word` is 0 and `excite_en` is 0.
- R2: Multi-byte configuration registers store their most significant byte at the lowest address: start at 0x82..0x84, step at 0x85..0x87, step count (9 bits) at 0x88..0x89, settling (11 bits) at 0x8A..0x8B. A read returns the byte on `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R3: Command code 0x1 (bits [7:4] of the byte written to 0x80) is accepted from idle or standby. It loads `freq_word` with the start word and raises `excite_en`, and no measurement is requested while the block stays in that state.
- R4: Command 0x2 after initialize waits for the settling total in `period_tick` pulses and then raises `meas_req`. On `meas_ack` it latches the results at 0x94/0x95 (real) and 0x96/0x97 (imaginary) and sets status bit 1 (data valid).
- R5: Command 0x3, accepted after a measurement, sets `freq_word` to the old word plus the step word, clears data valid and restarts settling.
- R6: Command 0x4, accepted after a measurement, keeps `freq_word`, clears data valid and sweep-complete, and restarts settling.
- R7: Status bit 2 (sweep complete) is set together with data valid when a measurement completes after the number of steps equals the programmed step count.
- R8: A command outside its legal state is ignored: step before a sweep has started, or step after sweep-complete, leaves `freq_word` and status unchanged.
- R9: The settling register holds the count in bits [8:0] and the multiplier in bits [10:9]: code 00 gives x1, 01 gives x2, 11 gives x4, and 10 is treated as x1.
- R10: Command 0x9 raises `temp_req` until `temp_ack`. It then stores the 14-bit two's complement value sign-extended to 16 bits at 0x92/0x93 and sets status bit 0.
- R11: Command 0xA (power down), or writing 1 to bit 4 of control-low (0x81), clears all status bits and drops `excite_en`. The reset bit reads back as 0.
- R12: Control-high bits [2:1] drive `out_range` and bit 0 drives `pga_unity`. Control-low bit 3 drives `ext_clk_sel` and reads back at 0x81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| bus_rvalid | output | 1 | Read byte valid |
| period_tick | input | 1 | One pulse per excitation period |
| meas_req | output | 1 | Measurement request |
| meas_ack | input | 1 | Measurement done, results valid |
| meas_re | input | 16 | Real result |
| meas_im | input | 16 | Imaginary result |
| temp_req | output | 1 | Temperature conversion request |
| temp_ack | input | 1 | Temperature conversion done |
| temp_in | input | 14 | Temperature result, two's complement |
| freq_word | output | 24 | Current frequency word |
| excite_en | output | 1 | Excitation active |
| out_range | output | 2 | Output range select |
| pga_unity | output | 1 | 1 = gain 1, 0 = gain 5 |
| ext_clk_sel | output | 1 | External system clock select |

## Verification
On every cycle the assertions check the read-response timing and that a measurement request only occurs while excitation is on. They also check that the frequency word holds through a measurement, that sweep-complete never stands without data valid, that the temperature request drops after its acknowledge, and that power-down and soft reset clear the flags. The bench scenarios are needed for everything that depends on a sequence: the number of excitation periods counted for each multiplier code, the arithmetic of the stepped frequency word, the placement of the last point, and commands dropped because they arrive in the wrong state.

// File: rtl/imp_sweep_pkg.sv
package imp_sweep_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'h0,
    OP_INIT   = 4'h1,
    OP_START  = 4'h2,
    OP_STEP   = 4'h3,
    OP_REPEAT = 4'h4,
    OP_TEMP   = 4'h9,
    OP_PDN    = 4'hA,
    OP_STBY   = 4'hB
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STBY, ST_PRIME, ST_SETTLE, ST_MEAS, ST_HOLD
  } seq_state_e;

  localparam logic [7:0] ADR_CTRL_HI = 8'h80;
  localparam logic [7:0] ADR_CTRL_LO = 8'h81;
  localparam logic [7:0] ADR_START   = 8'h82;
  localparam logic [7:0] ADR_STEP    = 8'h85;
  localparam logic [7:0] ADR_NUM     = 8'h88;
  localparam logic [7:0] ADR_SETTLE  = 8'h8A;
  localparam logic [7:0] ADR_STATUS  = 8'h8F;
  localparam logic [7:0] ADR_TEMP    = 8'h92;
  localparam logic [7:0] ADR_REAL    = 8'h94;
  localparam logic [7:0] ADR_IMAG    = 8'h96;

  localparam int STAT_TEMP = 0;
  localparam int STAT_DATA = 1;
  localparam int STAT_DONE = 2;
endpackage

// File: rtl/imp_sweep_regs.sv
module imp_sweep_regs
  import imp_sweep_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int NUM_W    = 9,
  parameter int SETTLE_W = 11,
  parameter int RES_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                bus_rvalid,
  input  logic [2:0]          status,
  input  logic [RES_W-1:0]    temp_q,
  input  logic [RES_W-1:0]    re_q,
  input  logic [RES_W-1:0]    im_q,
  output logic [7:0]          ctrl_hi,
  output logic                ext_clk,
  output logic [FREQ_W-1:0]   start_freq,
  output logic [FREQ_W-1:0]   step_freq,
  output logic [NUM_W-1:0]    num_steps,
  output logic [SETTLE_W-1:0] settle_cfg,
  output logic                cmd_stb,
  output logic [3:0]          cmd_code,
  output logic                soft_rst
);
  localparam int FB = FREQ_W / 8;

  logic [7:0] rd_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_hi    <= '0;
      ext_clk    <= 1'b0;
      start_freq <= '0;
      step_freq  <= '0;
      num_steps  <= '0;
      settle_cfg <= '0;
      cmd_stb    <= 1'b0;
      cmd_code   <= '0;
      soft_rst   <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      cmd_stb    <= 1'b0;
      soft_rst   <= 1'b0;
      bus_rvalid <= bus_sel && !bus_we;
      if (bus_sel && !bus_we) bus_rdata <= rd_byte;
      if (bus_sel && bus_we) begin
        if (bus_addr == ADR_CTRL_HI) begin
          ctrl_hi  <= bus_wdata;
          cmd_stb  <= 1'b1;
          cmd_code <= bus_wdata[7:4];
        end
        if (bus_addr == ADR_CTRL_LO) begin
          ext_clk  <= bus_wdata[3];
          soft_rst <= bus_wdata[4];
        end
        for (int b = 0; b < FB; b++) begin
          if (bus_addr == ADR_START + 8'(b)) start_freq[8*(FB-1-b) +: 8] <= bus_wdata;
          if (bus_addr == ADR_STEP  + 8'(b)) step_freq[8*(FB-1-b) +: 8]  <= bus_wdata;
        end
        if (bus_addr == ADR_NUM)           num_steps[NUM_W-1:8]     <= bus_wdata[NUM_W-9:0];
        if (bus_addr == ADR_NUM + 8'd1)    num_steps[7:0]           <= bus_wdata;
        if (bus_addr == ADR_SETTLE)        settle_cfg[SETTLE_W-1:8] <= bus_wdata[SETTLE_W-9:0];
        if (bus_addr == ADR_SETTLE + 8'd1) settle_cfg[7:0]          <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    case (bus_addr)
      ADR_CTRL_HI:        rd_byte = ctrl_hi;
      ADR_CTRL_LO:        rd_byte = {4'b0, ext_clk, 3'b0};
      ADR_NUM:            rd_byte = 8'(num_steps >> 8);
      ADR_NUM + 8'd1:     rd_byte = num_steps[7:0];
      ADR_SETTLE:         rd_byte = 8'(settle_cfg >> 8);
      ADR_SETTLE + 8'd1:  rd_byte = settle_cfg[7:0];
      ADR_STATUS:         rd_byte = {5'b0, status};
      ADR_TEMP:           rd_byte = temp_q[15:8];
      ADR_TEMP + 8'd1:    rd_byte = temp_q[7:0];
      ADR_REAL:           rd_byte = re_q[15:8];
      ADR_REAL + 8'd1:    rd_byte = re_q[7:0];
      ADR_IMAG:           rd_byte = im_q[15:8];
      ADR_IMAG + 8'd1:    rd_byte = im_q[7:0];
      default:            rd_byte = '0;
    endcase
    for (int b = 0; b < FB; b++) begin
      if (bus_addr == ADR_START + 8'(b)) rd_byte = start_freq[8*(FB-1-b) +: 8];
      if (bus_addr == ADR_STEP  + 8'(b)) rd_byte = step_freq[8*(FB-1-b) +: 8];
    end
  end
endmodule

// File: rtl/imp_sweep_settle.sv
module imp_sweep_settle #(
  parameter int CNT_W = 9,
  parameter int MUL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   tick,
  input  logic [CNT_W+MUL_W-1:0] cfg,
  output logic                   done
);
  localparam int REM_W = CNT_W + 2;

  logic [REM_W-1:0] remain;
  logic [REM_W-1:0] total;
  logic [CNT_W-1:0] base;

  assign base = cfg[CNT_W-1:0];

  always_comb begin
    case (cfg[CNT_W +: MUL_W])
      2'b01:   total = {1'b0, base, 1'b0};
      2'b11:   total = {base, 2'b00};
      default: total = {2'b00, base};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                      remain <= '0;
    else if (load)                remain <= total;
    else if (tick && remain != 0) remain <= remain - 1'b1;
  end

  assign done = (remain == '0) && !load;
endmodule

// File: rtl/imp_sweep_fsm.sv
module imp_sweep_fsm
  import imp_sweep_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int NUM_W  = 9,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [3:0]        cmd_code,
  input  logic              soft_rst,
  input  logic [FREQ_W-1:0] start_freq,
  input  logic [FREQ_W-1:0] step_freq,
  input  logic [NUM_W-1:0]  num_steps,
  input  logic              settle_done,
  input  logic              meas_ack,
  input  logic [RES_W-1:0]  meas_re,
  input  logic [RES_W-1:0]  meas_im,
  output logic              settle_load,
  output logic [FREQ_W-1:0] freq_word,
  output logic              excite_en,
  output logic              meas_req,
  output logic              data_valid,
  output logic              sweep_done,
  output logic [RES_W-1:0]  re_q,
  output logic [RES_W-1:0]  im_q
);
  seq_state_e state;
  op_e        op;
  logic [NUM_W-1:0] pts;
  logic acc_init, acc_start, acc_step, acc_rep, go_idle;

  assign op        = op_e'(cmd_code);
  assign go_idle   = soft_rst || (cmd_stb && op == OP_PDN);
  assign acc_init  = cmd_stb && op == OP_INIT && (state == ST_IDLE || state == ST_STBY);
  assign acc_start = cmd_stb && op == OP_START && state == ST_PRIME;
  assign acc_step  = cmd_stb && op == OP_STEP && state == ST_HOLD && !sweep_done;
  assign acc_rep   = cmd_stb && op == OP_REPEAT && state == ST_HOLD;
  assign settle_load = !go_idle && (acc_start || acc_step || acc_rep);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      freq_word  <= '0;
      pts        <= '0;
      data_valid <= 1'b0;
      sweep_done <= 1'b0;
      re_q       <= '0;
      im_q       <= '0;
    end else if (go_idle) begin
      state      <= ST_IDLE;
      data_valid <= 1'b0;
      sweep_done <= 1'b0;
    end else if (cmd_stb && op == OP_STBY) begin
      state <= ST_STBY;
    end else if (acc_init) begin
      state      <= ST_PRIME;
      freq_word  <= start_freq;
      pts        <= '0;
      data_valid <= 1'b0;
      sweep_done <= 1'b0;
    end else if (acc_start) begin
      state <= ST_SETTLE;
    end else if (acc_step) begin
      state      <= ST_SETTLE;
      freq_word  <= freq_word + step_freq;
      pts        <= pts + 1'b1;
      data_valid <= 1'b0;
    end else if (acc_rep) begin
      state      <= ST_SETTLE;
      data_valid <= 1'b0;
      sweep_done <= 1'b0;
    end else if (state == ST_SETTLE && settle_done) begin
      state <= ST_MEAS;
    end else if (state == ST_MEAS && meas_ack) begin
      state      <= ST_HOLD;
      re_q       <= meas_re;
      im_q       <= meas_im;
      data_valid <= 1'b1;
      sweep_done <= (pts == num_steps);
    end
  end

  assign meas_req  = (state == ST_MEAS);
  assign excite_en = (state == ST_PRIME) || (state == ST_SETTLE) ||
                     (state == ST_MEAS) || (state == ST_HOLD);
endmodule

// File: rtl/imp_sweep_temp.sv
module imp_sweep_temp
  import imp_sweep_pkg::*;
#(
  parameter int TEMP_W = 14,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [3:0]        cmd_code,
  input  logic              soft_rst,
  input  logic              temp_ack,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              temp_req,
  output logic              temp_valid,
  output logic [RES_W-1:0]  temp_q
);
  op_e op;
  assign op = op_e'(cmd_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_req   <= 1'b0;
      temp_valid <= 1'b0;
      temp_q     <= '0;
    end else if (soft_rst || (cmd_stb && op == OP_PDN)) begin
      temp_req   <= 1'b0;
      temp_valid <= 1'b0;
    end else if (cmd_stb && op == OP_TEMP && !temp_req) begin
      temp_req   <= 1'b1;
      temp_valid <= 1'b0;
    end else if (temp_req && temp_ack) begin
      temp_req   <= 1'b0;
      temp_valid <= 1'b1;
      temp_q     <= {{(RES_W-TEMP_W){temp_in[TEMP_W-1]}}, temp_in};
    end
  end
endmodule

// File: rtl/imp_sweep_seq.sv
module imp_sweep_seq
  import imp_sweep_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int NUM_W    = 9,
  parameter int CNT_W    = 9,
  parameter int MUL_W    = 2,
  parameter int RES_W    = 16,
  parameter int TEMP_W   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic              period_tick,
  output logic              meas_req,
  input  logic              meas_ack,
  input  logic [RES_W-1:0]  meas_re,
  input  logic [RES_W-1:0]  meas_im,
  output logic              temp_req,
  input  logic              temp_ack,
  input  logic [TEMP_W-1:0] temp_in,
  output logic [FREQ_W-1:0] freq_word,
  output logic              excite_en,
  output logic [1:0]        out_range,
  output logic              pga_unity,
  output logic              ext_clk_sel
);
  localparam int SETTLE_W = CNT_W + MUL_W;

  logic [7:0]          ctrl_hi;
  logic [FREQ_W-1:0]   start_freq, step_freq;
  logic [NUM_W-1:0]    num_steps;
  logic [SETTLE_W-1:0] settle_cfg;
  logic                cmd_stb, soft_rst;
  logic [3:0]          cmd_code;
  logic [2:0]          status;
  logic [RES_W-1:0]    temp_q, re_q, im_q;
  logic                settle_load, settle_done;
  logic                data_valid, sweep_done, temp_valid;

  assign status[STAT_TEMP] = temp_valid;
  assign status[STAT_DATA] = data_valid;
  assign status[STAT_DONE] = sweep_done;

  imp_sweep_regs #(.FREQ_W(FREQ_W), .NUM_W(NUM_W), .SETTLE_W(SETTLE_W), .RES_W(RES_W)) i_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .status(status), .temp_q(temp_q), .re_q(re_q), .im_q(im_q),
    .ctrl_hi(ctrl_hi), .ext_clk(ext_clk_sel), .start_freq(start_freq),
    .step_freq(step_freq), .num_steps(num_steps), .settle_cfg(settle_cfg),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .soft_rst(soft_rst)
  );

  imp_sweep_settle #(.CNT_W(CNT_W), .MUL_W(MUL_W)) i_settle (
    .clk(clk), .rst(rst), .load(settle_load), .tick(period_tick),
    .cfg(settle_cfg), .done(settle_done)
  );

  imp_sweep_fsm #(.FREQ_W(FREQ_W), .NUM_W(NUM_W), .RES_W(RES_W)) i_fsm (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .soft_rst(soft_rst),
    .start_freq(start_freq), .step_freq(step_freq), .num_steps(num_steps),
    .settle_done(settle_done), .meas_ack(meas_ack), .meas_re(meas_re), .meas_im(meas_im),
    .settle_load(settle_load), .freq_word(freq_word), .excite_en(excite_en),
    .meas_req(meas_req), .data_valid(data_valid), .sweep_done(sweep_done),
    .re_q(re_q), .im_q(im_q)
  );

  imp_sweep_temp #(.TEMP_W(TEMP_W), .RES_W(RES_W)) i_temp (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .soft_rst(soft_rst),
    .temp_ack(temp_ack), .temp_in(temp_in), .temp_req(temp_req),
    .temp_valid(temp_valid), .temp_q(temp_q)
  );

  assign out_range = ctrl_hi[2:1];
  assign pga_unity = ctrl_hi[0];
endmodule

// File: rtl/imp_sweep_chk.sv
module imp_sweep_chk #(
  parameter int FREQ_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_rvalid,
  input logic              meas_req,
  input logic              excite_en,
  input logic [FREQ_W-1:0] freq_word,
  input logic              temp_req,
  input logic              temp_ack,
  input logic [2:0]        status,
  input logic              cmd_stb,
  input logic [3:0]        cmd_code,
  input logic              soft_rst
);
  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);

  // R4
  req_excite_chk: assert property (@(posedge clk) disable iff (rst)
    meas_req |-> excite_en);

  // R5
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    meas_req |=> $stable(freq_word));

  // R7
  done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    status[2] |-> status[1]);

  // R10
  temp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_req && temp_ack) |=> !temp_req);

  // R11
  pdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_code == 4'hA) |=> (status == 3'b000 && !excite_en));

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (status == 3'b000 && !excite_en));
endmodule

bind imp_sweep_seq imp_sweep_chk #(.FREQ_W(FREQ_W)) i_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_rvalid(bus_rvalid),
  .meas_req(meas_req), .excite_en(excite_en), .freq_word(freq_word),
  .temp_req(temp_req), .temp_ack(temp_ack), .status(status),
  .cmd_stb(cmd_stb), .cmd_code(cmd_code), .soft_rst(soft_rst)
);

// File: tb/test_imp_sweep_seq.sv
module test_imp_sweep_seq;
  localparam time CLK_PER = 10ns;

  logic        clk = 0, rst = 1;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic        period_tick = 0;
  logic        meas_req, meas_ack = 0;
  logic [15:0] meas_re = 0, meas_im = 0;
  logic        temp_req, temp_ack = 0;
  logic [13:0] temp_in = 14'h3FFB;
  logic [23:0] freq_word;
  logic        excite_en;
  logic [1:0]  out_range;
  logic        pga_unity, ext_clk_sel;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int  midx = 0, tick_cnt = 0, got_ticks = -1, div = 0;
  bit  counting = 0;

  always #(CLK_PER/2) clk = ~clk;

  imp_sweep_seq i_imp_sweep_seq (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .period_tick(period_tick), .meas_req(meas_req), .meas_ack(meas_ack),
    .meas_re(meas_re), .meas_im(meas_im), .temp_req(temp_req), .temp_ack(temp_ack),
    .temp_in(temp_in), .freq_word(freq_word), .excite_en(excite_en),
    .out_range(out_range), .pga_unity(pga_unity), .ext_clk_sel(ext_clk_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stimulus responders and tick generator, all on the falling edge
  always @(negedge clk) begin
    if (meas_req) begin
      meas_ack = 1;
      meas_re  = 16'h1000 + 16'(midx);
      meas_im  = 16'h8000 + 16'(midx);
      midx++;
      if (counting) begin got_ticks = tick_cnt; counting = 0; end
    end else meas_ack = 0;
    temp_ack = temp_req;
    if (counting) begin
      div++;
      if (div == 4) begin div = 0; period_tick = 1; tick_cnt++; end
      else period_tick = 0;
    end else begin
      div = 0; period_tick = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic cmd(input logic [3:0] op);
    wr(8'h80, {op, 4'h5});
    idle(3);
  endtask

  task automatic settle_run(input int exp_ticks, input string tag);
    @(posedge clk);
    tick_cnt = 0; got_ticks = -1; counting = 1;
    for (int i = 0; i < 400 && counting; i++) @(negedge clk);
    counting = 0;
    chk(tag, 32'(got_ticks), 32'(exp_ticks));
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0;
    idle(2);
    // R1 reset state
    rd(8'h8F, 8'h00, "R1 status");
    chk("R1 freq_word", 32'(freq_word), 0);
    chk("R1 excite_en", 32'(excite_en), 0);

    // R2 configuration, MSB first
    wr(8'h82, 8'h12); wr(8'h83, 8'h34); wr(8'h84, 8'h56);
    wr(8'h85, 8'h00); wr(8'h86, 8'h01); wr(8'h87, 8'h00);
    wr(8'h88, 8'h00); wr(8'h89, 8'h02);
    wr(8'h8A, 8'h02); wr(8'h8B, 8'h03);   // count 3, code 01 -> x2
    rd(8'h82, 8'h12, "R2 start msb");
    rd(8'h83, 8'h34, "R2 start mid");
    rd(8'h84, 8'h56, "R2 start lsb");
    rd(8'h86, 8'h01, "R2 step mid");
    rd(8'h89, 8'h02, "R2 num lsb");
    rd(8'h8A, 8'h02, "R2 settle msb");
    rd(8'h8B, 8'h03, "R2 settle lsb");

    // R8 step while idle is dropped
    cmd(4'h3);
    chk("R8 step from idle freq", 32'(freq_word), 0);
    chk("R8 step from idle excite", 32'(excite_en), 0);

    // R3 initialize
    cmd(4'h1);
    chk("R3 freq after init", 32'(freq_word), 32'h123456);
    chk("R3 excite after init", 32'(excite_en), 1);
    @(posedge clk); counting = 1;
    idle(40);
    counting = 0;
    chk("R3 no measurement while primed", 32'(midx), 0);
    cmd(4'h3);
    chk("R8 step before start", 32'(freq_word), 32'h123456);

    // R4 start, R9 x2 multiplier
    cmd(4'h2);
    settle_run(6, "R9 x2 settle ticks");
    rd(8'h8F, 8'h02, "R4 data valid");
    rd(8'h94, 8'h10, "R4 real msb");
    rd(8'h95, 8'h00, "R4 real lsb");
    rd(8'h96, 8'h80, "R4 imag msb");

    // R5 step
    cmd(4'h3);
    chk("R5 stepped word", 32'(freq_word), 32'h123556);
    rd(8'h8F, 8'h00, "R5 valid cleared");
    settle_run(6, "R5 settle after step");
    rd(8'h95, 8'h01, "R5 real lsb");

    // R6 repeat
    cmd(4'h4);
    chk("R6 word kept", 32'(freq_word), 32'h123556);
    rd(8'h8F, 8'h00, "R6 valid cleared");
    settle_run(6, "R6 settle after repeat");
    rd(8'h95, 8'h02, "R6 real lsb");

    // R7 last point
    cmd(4'h3);
    settle_run(6, "R7 settle last");
    chk("R7 last word", 32'(freq_word), 32'h123656);
    rd(8'h8F, 8'h06, "R7 done and valid");
    rd(8'h95, 8'h03, "R7 real lsb");

    // R8 step after done
    cmd(4'h3);
    chk("R8 step after done word", 32'(freq_word), 32'h123656);
    rd(8'h8F, 8'h06, "R8 step after done status");

    // R9 x4 multiplier
    wr(8'h8A, 8'h06); wr(8'h8B, 8'h02);   // count 2, code 11 -> x4
    cmd(4'hB);
    cmd(4'h1);
    chk("R3 reinit word", 32'(freq_word), 32'h123456);
    rd(8'h8F, 8'h00, "R3 reinit clears status");
    cmd(4'h2);
    settle_run(8, "R9 x4 settle ticks");

    // R10 temperature
    cmd(4'h9);
    idle(3);
    chk("R10 temp req dropped", 32'(temp_req), 0);
    rd(8'h8F, 8'h03, "R10 temp valid");
    rd(8'h92, 8'hFF, "R10 temp msb sign");
    rd(8'h93, 8'hFB, "R10 temp lsb");

    // R12 control fields
    chk("R12 out_range", 32'(out_range), 2);
    chk("R12 pga_unity", 32'(pga_unity), 1);
    wr(8'h81, 8'h08);
    idle(2);
    chk("R12 ext clk", 32'(ext_clk_sel), 1);
    rd(8'h81, 8'h08, "R12 ctrl low readback");

    // R11 power down
    cmd(4'hA);
    rd(8'h8F, 8'h00, "R11 pdn status");
    chk("R11 pdn excite", 32'(excite_en), 0);

    // R11 soft reset
    cmd(4'h1);
    cmd(4'h9);
    idle(3);
    rd(8'h8F, 8'h01, "R11 temp before soft reset");
    wr(8'h81, 8'h18);
    idle(3);
    rd(8'h8F, 8'h00, "R11 soft reset status");
    chk("R11 soft reset excite", 32'(excite_en), 0);
    rd(8'h81, 8'h08, "R11 reset bit self clears");

    idle(4);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule